// File: doc/BRIEF.md
# Opmask to Vector Broadcast Unit

This execution-unit block receives one decoded instruction per strobe and, when the encoding is one of its two broadcast forms, copies a zero-extended slice of a 16-bit opmask into every element of a vector destination up to 512 bits wide. The byte form places the low eight mask bits into each 64-bit element. The word form places the low sixteen mask bits into each 32-bit element. Every destination bit at or above the selected vector length reads as zero.

Encodings that are not legal produce an invalid-opcode fault pulse and no result. Illegal encodings are an unknown opcode/W pair, a reserved vector-length code, or a register field other than all ones. Result, valid flag and fault flag are registered one clock after the input strobe.

Top module: `opmask_bcast_unit`

## Requirements
- R1: Opcode 8'h2A with W=1 is the byte form: each 64-bit element j inside the active length holds {56'b0, mask[7:0]}.
- R2: Opcode 8'h3A with W=0 is the word form: each 32-bit element j inside the active length holds {16'b0, mask[15:0]}.
- R3: Vector-length code 2'b00 selects 128 bits, 2'b01 selects 256 and 2'b10 selects 512. Every result bit from the active length up to bit 511 is zero.
- R4: A register field other than 4'b1111 raises the fault, keeps the valid flag low, and leaves the result register unchanged.
- R5: Vector-length code 2'b11 raises the fault with no result.
- R6: Any opcode/W pair other than the two in R1 and R2 raises the fault with no result.
- R7: Mask bits above the slice used by the form (mask[15:8] in the byte form) have no effect on the result.
- R8: Valid and fault appear exactly one clock after the strobe and last one cycle. With no strobe, both flags are low and the result holds.
- R9: A synchronous active-low reset clears the result register and both flags.
- R10: The valid flag and the fault flag are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction strobe |
| in_opcode | input | 8 | Opcode byte |
| in_w | input | 1 | W bit of the encoding |
| in_vlen | input | 2 | Vector-length code |
| in_vreg | input | 4 | Reserved register field, must be all ones |
| in_mask | input | 16 | Opmask source value |
| out_data | output | 512 | Registered broadcast result |
| out_valid | output | 1 | Result valid pulse |
| out_fault | output | 1 | Invalid-opcode fault pulse |

## Verification
Both forms are driven at all three vector lengths. The mask values are chosen with distinct high and low bytes, so a byte/word swap or a wrong element pitch changes the image. A value with a set top byte in the byte form shows whether mask[15:8] leaks in. One value with all ones shows where the zero region begins. Each illegal cause is given alone: a wrong register field, the reserved length code, swapped W, and a foreign opcode. These show whether each check is decoded on its own. They also show that a fault leaves the earlier result intact. Idle cycles and a reset taken after a result confirm the one-cycle pulse and the cleared state.

// File: rtl/opmask_bcast_pkg.sv
// Shared constants and types for the opmask broadcast unit.
// Assumes a 512-bit maximum vector and a 32-bit lane slot grid.
package opmask_bcast_pkg;
    localparam int unsigned MAX_VEC_W = 512;
    localparam int unsigned SLOT_W    = 32;
    localparam int unsigned MASK_W    = 16;
    localparam int unsigned NUM_SLOTS = MAX_VEC_W / SLOT_W;

    localparam logic [7:0] OPC_BYTE_FORM = 8'h2A;
    localparam logic [7:0] OPC_WORD_FORM = 8'h3A;

    typedef enum logic [1:0] {
        VL_128  = 2'b00,
        VL_256  = 2'b01,
        VL_512  = 2'b10,
        VL_RSVD = 2'b11
    } vlen_e;

    typedef enum logic {
        FMT_BYTE_Q = 1'b0,
        FMT_WORD_D = 1'b1
    } bcast_fmt_e;

    typedef struct packed {
        logic       legal;
        bcast_fmt_e fmt;
        vlen_e      vlen;
    } dec_t;
endpackage

// File: rtl/opmask_bcast_decode.sv
// Decodes opcode, W bit, length code and register field into a format and
// a legality flag. Purely combinational; assumes inputs are stable when the
// strobe is sampled.
module opmask_bcast_decode
    import opmask_bcast_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       w_bit,
    input  logic [1:0] vlen,
    input  logic [3:0] vreg,
    output dec_t       dec
);
    logic is_byte;
    logic is_word;

    // Classify the form and combine every legality condition.
    always_comb begin
        is_byte   = (opcode == OPC_BYTE_FORM) && w_bit;
        is_word   = (opcode == OPC_WORD_FORM) && !w_bit;
        dec.fmt   = is_word ? FMT_WORD_D : FMT_BYTE_Q;
        dec.vlen  = vlen_e'(vlen);
        dec.legal = (is_byte || is_word)
                    && (vlen != VL_RSVD)
                    && (vreg == 4'hF);
    end
endmodule

// File: rtl/opmask_bcast_fill.sv
// Builds the full-width broadcast image from a mask and a decoded format.
// Each 32-bit slot is generated separately. A slot above the active length is
// zero. In the byte form, odd slots hold the upper, zero half of each 64-bit
// element.
module opmask_bcast_fill
    import opmask_bcast_pkg::*;
#(
    parameter int unsigned VEC_W  = MAX_VEC_W,
    parameter int unsigned SLOT   = SLOT_W,
    parameter int unsigned MASK_N = MASK_W
) (
    input  logic [MASK_N-1:0] mask,
    input  bcast_fmt_e        fmt,
    input  vlen_e             vlen,
    output logic [VEC_W-1:0]  image
);
    localparam int unsigned SLOTS    = VEC_W / SLOT;
    localparam int unsigned BASE_VL  = 128;
    localparam int unsigned CNT_W    = $clog2(SLOTS + 1);

    logic [CNT_W-1:0] active_slots;

    // Number of 32-bit slots covered by the selected vector length.
    always_comb begin
        active_slots = CNT_W'((BASE_VL << vlen) / SLOT);
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [SLOT-1:0] slot_val;
        // Value for this slot from form, parity and length.
        always_comb begin
            slot_val = '0;
            if (CNT_W'(k) < active_slots) begin
                if (fmt == FMT_WORD_D)
                    slot_val = SLOT'(mask);
                else if ((k % 2) == 0)
                    slot_val = SLOT'(mask[7:0]);
            end
        end
        assign image[k*SLOT +: SLOT] = slot_val;
    end
endmodule

// File: rtl/opmask_bcast_unit.sv
// Top of the opmask broadcast unit. Registers the broadcast image one clock
// after a legal strobe, or pulses a fault on an illegal one and holds the
// previous result. Synchronous active-low reset.
module opmask_bcast_unit
    import opmask_bcast_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_opcode,
    input  logic                 in_w,
    input  logic [1:0]           in_vlen,
    input  logic [3:0]           in_vreg,
    input  logic [MASK_W-1:0]    in_mask,
    output logic [MAX_VEC_W-1:0] out_data,
    output logic                 out_valid,
    output logic                 out_fault
);
    dec_t                 dec;
    logic [MAX_VEC_W-1:0] image;

    opmask_bcast_decode u_decode (
        .opcode (in_opcode),
        .w_bit  (in_w),
        .vlen   (in_vlen),
        .vreg   (in_vreg),
        .dec    (dec)
    );

    opmask_bcast_fill #(
        .VEC_W  (MAX_VEC_W),
        .SLOT   (SLOT_W),
        .MASK_N (MASK_W)
    ) u_fill (
        .mask   (in_mask),
        .fmt    (dec.fmt),
        .vlen   (dec.vlen),
        .image  (image)
    );

    // Capture the result and the flag pulses on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= in_valid && dec.legal;
            out_fault <= in_valid && !dec.legal;
            if (in_valid && dec.legal)
                out_data <= image;
        end
    end
endmodule

// File: rtl/opmask_bcast_checker.sv
// Assertion checker for the opmask broadcast unit, attached with bind.
module opmask_bcast_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   in_vlen,
    input logic [3:0]   in_vreg,
    input logic [511:0] out_data,
    input logic         out_valid,
    input logic         out_fault
);
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault));

    assert_bad_vreg_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vreg != 4'hF) |=> (out_fault && !out_valid));

    assert_fault_holds_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> $stable(out_data));

    assert_rsvd_vlen_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vlen == 2'b11) |=> out_fault);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_fault && $stable(out_data)));

    assert_vl128_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vlen == 2'b00) |=> (!out_valid || out_data[511:128] == '0));

    assert_vl256_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vlen == 2'b01) |=> (!out_valid || out_data[511:256] == '0));
endmodule

bind opmask_bcast_unit opmask_bcast_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vlen   (in_vlen),
    .in_vreg   (in_vreg),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_fault (out_fault)
);

// File: tb/opmask_bcast_unit_bench.sv
module opmask_bcast_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [7:0]   in_opcode;
    logic         in_w;
    logic [1:0]   in_vlen;
    logic [3:0]   in_vreg;
    logic [15:0]  in_mask;
    logic [511:0] out_data;
    logic         out_valid;
    logic         out_fault;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [511:0] last_data;

    always #5 clk = ~clk;

    opmask_bcast_unit u_opmask_bcast_unit (.*);

    // Vector fields: {opcode, w, vlen, vreg, mask}
    localparam int NV = 14;
    localparam logic [30:0] VECS [NV] = '{
        {8'h2A, 1'b1, 2'b00, 4'hF, 16'hA5C3},
        {8'h2A, 1'b1, 2'b01, 4'hF, 16'hFF81},
        {8'h2A, 1'b1, 2'b10, 4'hF, 16'h007E},
        {8'h3A, 1'b0, 2'b00, 4'hF, 16'hBEEF},
        {8'h3A, 1'b0, 2'b01, 4'hF, 16'h1234},
        {8'h3A, 1'b0, 2'b10, 4'hF, 16'hFFFF},
        {8'h3A, 1'b0, 2'b10, 4'hE, 16'h1111},
        {8'h2A, 1'b1, 2'b11, 4'hF, 16'h00FF},
        {8'h2A, 1'b0, 2'b10, 4'hF, 16'h00FF},
        {8'h3A, 1'b1, 2'b10, 4'hF, 16'h00FF},
        {8'h1A, 1'b1, 2'b10, 4'hF, 16'h00FF},
        {8'h2A, 1'b1, 2'b10, 4'h0, 16'h00FF},
        {8'h2A, 1'b1, 2'b10, 4'hF, 16'h5A3C},
        {8'h3A, 1'b0, 2'b11, 4'hF, 16'h4444}
    };

    // Reference model written from R1..R6.
    function automatic logic model_legal(logic [30:0] v);
        logic [7:0] op = v[30:23];
        logic       w  = v[22];
        return (((op == 8'h2A) && w) || ((op == 8'h3A) && !w))
               && (v[21:20] != 2'b11) && (v[19:16] == 4'hF);
    endfunction

    function automatic logic [511:0] model_data(logic [30:0] v);
        logic [511:0] d = '0;
        int vl = 128 << v[21:20];
        if (v[30:23] == 8'h2A) begin
            for (int e = 0; e < vl / 64; e++) d[e*64 +: 64] = {56'b0, v[7:0]};
        end else begin
            for (int e = 0; e < vl / 32; e++) d[e*32 +: 32] = {16'b0, v[15:0]};
        end
        return d;
    endfunction

    task automatic check(string req, logic [511:0] act, logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [30:0] v, logic vld);
        @(negedge clk);
        in_valid  = vld;
        in_opcode = v[30:23];
        in_w      = v[22];
        in_vlen   = v[21:20];
        in_vreg   = v[19:16];
        in_mask   = v[15:0];
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_w = 1'b0;
        in_vlen = '0; in_vreg = '0; in_mask = '0;
        repeat (3) @(negedge clk);
        check("R9 reset data", out_data, '0);
        check("R9 reset valid", 512'(out_valid), 512'(0));
        check("R9 reset fault", 512'(out_fault), 512'(0));
        rst_n = 1'b1;
        last_data = '0;

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            logic lg;
            lg = model_legal(VECS[i]);
            drive(VECS[i], 1'b1);
            check("R8/R10 valid", 512'(out_valid), 512'(lg));
            check("R4/R5/R6 fault", 512'(out_fault), 512'(!lg));
            if (lg) last_data = model_data(VECS[i]);
            check("R1/R2/R3/R4 data", out_data, last_data);
        end

        // R8: flags drop one cycle later; data holds with no strobe
        @(negedge clk);
        check("R8 valid drops", 512'(out_valid), 512'(0));
        check("R8 fault drops", 512'(out_fault), 512'(0));
        check("R8 data holds", out_data, last_data);

        // R7: top mask byte ignored in byte form
        drive({8'h2A, 1'b1, 2'b10, 4'hF, 16'h0033}, 1'b1);
        last_data = out_data;
        drive({8'h2A, 1'b1, 2'b10, 4'hF, 16'hCC33}, 1'b1);
        check("R7 high mask ignored", out_data, last_data);
        check("R1 element 7", 512'(out_data[511:448]), 512'(64'h33));

        // R3: 512-bit word form top element
        drive({8'h3A, 1'b0, 2'b10, 4'hF, 16'h8001}, 1'b1);
        check("R2/R3 top element", 512'(out_data[511:480]), 512'(32'h8001));

        // R9: reset after a result clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears data", out_data, '0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule